// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block produces the SCL and SDA line timing for the master side of an I2C bus. It takes one 32-bit timing word and a command strobe, then runs the bus lines through a START, a data bit, a repeated START or a STOP. A prescaler turns the kernel clock into a timing tick. Counters clocked by that tick set the SCL low and high periods, the data hold delay that follows an SCL fall, and the data setup delay that precedes an SCL rise. START hold, STOP setup, repeated-START setup and bus-free time use the same low and high counts.

Both lines are driven as open-drain pull-down enables. A sampled copy of SCL comes back in, so the high-phase count waits while a slave holds the clock low. A higher-level controller issues one command, waits for the one-cycle done pulse, and then issues the next. Byte framing and acknowledge handling belong to that controller.

Top module: `i2c_bit_timer`

## Requirements
- R1: The timing word has these fields: SCL-low count LO in bits 7:0, SCL-high count HI in bits 15:8, hold count HD in bits 19:16, setup count SU in bits 23:20 and prescaler P in bits 31:28. Bits 27:24 have no effect.
- R2: One tick lasts P+1 kernel clocks. All phase durations below are whole ticks, counted from the clock edge that accepts the command.
- R3: START from the free bus pulls SDA at once, keeps SCL released for HI+1 ticks, then pulls SCL low and raises done.
- R4: For a data bit, SDA changes HD ticks after acceptance, or at acceptance when HD is 0. SDA is pulled when tx_bit is 0 and released when tx_bit is 1.
- R5: SCL stays pulled for L = max(HD+SU+1, LO+1) ticks after a command accepted in the held state, and is then released.
- R6: After SCL is released, the high count of HI+1 ticks begins only on the first clock in which scl_in reads high. Each clock in which scl_in is held low adds one clock. SDA does not move during the data-bit high phase.
- R7: A repeated START (the START command while the bus is held) releases SDA after HD ticks and releases SCL after L ticks. It then pulls SDA after a further LO+1 ticks, and pulls SCL and raises done after a further HI+1 ticks.
- R8: STOP pulls SDA after HD ticks and releases SCL after L ticks. It releases SDA after a further HI+1 ticks, then waits a bus-free time of LO+1 ticks before it raises done and returns to idle.
- R9: done is high for exactly one kernel clock per completed command, in the first clock after the final phase ends.
- R10: A change to the timing word while a command runs has no effect on that command.
- R11: After reset and in idle, both lines are released and done is low. BIT and STOP in idle are ignored. Any command while a command runs is ignored.
- R12: cmd_op encodes 0 as START, 1 as BIT, 2 as STOP, and 3 as no operation, which is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_word | input | 32 | Timing word |
| cmd_valid | input | 1 | Command strobe, one clock |
| cmd_op | input | 2 | Command code |
| tx_bit | input | 1 | Bit value for BIT |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pd | output | 1 | Pull SCL low when 1 |
| sda_pd | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps the prescaler, the low count, the high count, the hold count and the setup count over small sets of values. For each combination it runs START, data bits 0, 1 and a repeated 1, a repeated START, another bit and a STOP. Some sweep points have the hold and setup sum larger than the low count and some have it smaller, so both branches of the low-phase maximum are taken. A zero hold count tests the skipped hold phase, and a repeated bit value tests that an unchanged SDA produces no edge. The reserved bits alternate between two patterns across the sweep. Directed runs cover a slave stretching the clock, a timing-word change and a stray command during a running bit, a no-op command, and BIT and STOP on a free bus.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

  localparam int CFG_W     = 32;
  localparam int LOW_W     = 8;
  localparam int HIGH_W    = 8;
  localparam int DEL_W     = 4;
  localparam int PRE_W     = 4;
  localparam int LOW_LSB   = 0;
  localparam int HIGH_LSB  = 8;
  localparam int HOLD_LSB  = 16;
  localparam int SETUP_LSB = 20;
  localparam int PRE_LSB   = 28;
  localparam int CNT_W     = ((LOW_W > HIGH_W) ? LOW_W : HIGH_W) + 1;

  typedef struct packed {
    logic [PRE_W-1:0]  presc;
    logic [DEL_W-1:0]  setup;
    logic [DEL_W-1:0]  hold;
    logic [HIGH_W-1:0] high;
    logic [LOW_W-1:0]  low;
  } timing_t;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HELD, ST_START,
    ST_RS_HOLD, ST_RS_SETUP, ST_RS_HIGH,
    ST_BIT_HOLD, ST_BIT_SETUP, ST_BIT_HIGH,
    ST_SP_HOLD, ST_SP_SETUP, ST_SP_HIGH, ST_SP_FREE
  } state_e;

  function automatic timing_t unpack_timing(input logic [CFG_W-1:0] w);
    timing_t t;
    t.low   = w[LOW_LSB   +: LOW_W];
    t.high  = w[HIGH_LSB  +: HIGH_W];
    t.hold  = w[HOLD_LSB  +: DEL_W];
    t.setup = w[SETUP_LSB +: DEL_W];
    t.presc = w[PRE_LSB   +: PRE_W];
    return t;
  endfunction

  function automatic logic st_busy(input state_e s);
    return (s != ST_IDLE) && (s != ST_HELD);
  endfunction

  function automatic logic st_scl_pulled(input state_e s);
    return (s == ST_HELD)     || (s == ST_RS_HOLD)  || (s == ST_RS_SETUP) ||
           (s == ST_BIT_HOLD) || (s == ST_BIT_SETUP) ||
           (s == ST_SP_HOLD)  || (s == ST_SP_SETUP);
  endfunction

  function automatic logic st_low_phase(input state_e s);
    return (s == ST_RS_HOLD)  || (s == ST_RS_SETUP) ||
           (s == ST_BIT_HOLD) || (s == ST_BIT_SETUP) ||
           (s == ST_SP_HOLD)  || (s == ST_SP_SETUP);
  endfunction

  function automatic logic st_high_phase(input state_e s);
    return (s == ST_RS_HIGH) || (s == ST_BIT_HIGH) || (s == ST_SP_HIGH);
  endfunction

endpackage

// File: rtl/i2c_tm_prescaler.sv
module i2c_tm_prescaler
  import i2c_tm_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [PW-1:0] presc,
  output logic          tick
);

  localparam logic [PW-1:0] PRE_ONE = PW'(1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = !clear && (cnt_q == presc);

  always_comb begin
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + PRE_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) |=> !tick);

endmodule

// File: rtl/i2c_tm_counters.sv
module i2c_tm_counters
  import i2c_tm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ph_clr,
  input  logic          low_run,
  output logic [CW-1:0] ph_cnt,
  output logic [CW-1:0] low_cnt
);

  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic [CW-1:0] ph_q, ph_d, low_q, low_d;

  always_comb begin
    ph_d = ph_q;
    if (ph_clr)                   ph_d = '0;
    else if (tick && ph_q != '1)  ph_d = ph_q + C_ONE;
  end

  always_comb begin
    low_d = low_q;
    if (!low_run)                 low_d = '0;
    else if (tick && low_q != '1) low_d = low_q + C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      low_q <= '0;
    end else begin
      ph_q  <= ph_d;
      low_q <= low_d;
    end
  end

  assign ph_cnt  = ph_q;
  assign low_cnt = low_q;

endmodule

// File: rtl/i2c_tm_seq.sv
module i2c_tm_seq
  import i2c_tm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          tx_bit,
  input  logic          scl_in,
  input  timing_t       cfg_live,
  input  logic          tick,
  input  logic [CW-1:0] ph_cnt,
  input  logic [CW-1:0] low_cnt,
  output timing_t       cfg_eff,
  output logic          pre_clear,
  output logic          ph_clr,
  output logic          low_run,
  output logic          scl_pd,
  output logic          sda_pd,
  output logic          done
);

  localparam logic [CW-1:0] C_ONE = CW'(1);

  state_e  state_q, state_d;
  timing_t cfg_q;
  logic    sda_q, sda_d, bit_q, bit_d, done_q, done_d, scl_q;
  logic    busy, stretch_wait;
  logic [CW-1:0] lo_x, hi_x, hd_x, su_x;
  logic    hold_last, setup_last, high_last, low_last;
  op_e     op;

  assign busy    = st_busy(state_q);
  assign cfg_eff = busy ? cfg_q : cfg_live;
  assign op      = op_e'(cmd_op);

  assign lo_x = CW'(cfg_eff.low);
  assign hi_x = CW'(cfg_eff.high);
  assign hd_x = CW'(cfg_eff.hold);
  assign su_x = CW'(cfg_eff.setup);

  // phase-end conditions, evaluated on the tick that completes the phase
  assign hold_last  = tick && (ph_cnt + C_ONE == hd_x);
  assign setup_last = tick && (ph_cnt >= su_x) && (low_cnt >= lo_x);
  assign high_last  = tick && (ph_cnt == hi_x);
  assign low_last   = tick && (ph_cnt == lo_x);

  assign stretch_wait = st_high_phase(state_q) && !scl_in;
  assign pre_clear    = !busy || stretch_wait;
  assign ph_clr       = (state_d != state_q) || stretch_wait;
  assign low_run      = st_low_phase(state_q);

  always_comb begin
    state_d = state_q;
    sda_d   = sda_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid && op == OP_START) begin
          state_d = ST_START;
          sda_d   = 1'b1;
        end
      end
      ST_HELD: begin
        if (cmd_valid) begin
          case (op)
            OP_START: begin
              if (cfg_eff.hold == '0) begin
                state_d = ST_RS_SETUP;
                sda_d   = 1'b0;
              end else begin
                state_d = ST_RS_HOLD;
              end
            end
            OP_BIT: begin
              bit_d = tx_bit;
              if (cfg_eff.hold == '0) begin
                state_d = ST_BIT_SETUP;
                sda_d   = !tx_bit;
              end else begin
                state_d = ST_BIT_HOLD;
              end
            end
            OP_STOP: begin
              if (cfg_eff.hold == '0) begin
                state_d = ST_SP_SETUP;
                sda_d   = 1'b1;
              end else begin
                state_d = ST_SP_HOLD;
              end
            end
            default: state_d = ST_HELD;
          endcase
        end
      end
      ST_START: begin
        if (high_last) begin
          state_d = ST_HELD;
          done_d  = 1'b1;
        end
      end
      ST_RS_HOLD: begin
        if (hold_last) begin
          state_d = ST_RS_SETUP;
          sda_d   = 1'b0;
        end
      end
      ST_RS_SETUP: if (setup_last) state_d = ST_RS_HIGH;
      ST_RS_HIGH: begin
        if (low_last) begin
          state_d = ST_START;
          sda_d   = 1'b1;
        end
      end
      ST_BIT_HOLD: begin
        if (hold_last) begin
          state_d = ST_BIT_SETUP;
          sda_d   = !bit_q;
        end
      end
      ST_BIT_SETUP: if (setup_last) state_d = ST_BIT_HIGH;
      ST_BIT_HIGH: begin
        if (high_last) begin
          state_d = ST_HELD;
          done_d  = 1'b1;
        end
      end
      ST_SP_HOLD: begin
        if (hold_last) begin
          state_d = ST_SP_SETUP;
          sda_d   = 1'b1;
        end
      end
      ST_SP_SETUP: if (setup_last) state_d = ST_SP_HIGH;
      ST_SP_HIGH: begin
        if (high_last) begin
          state_d = ST_SP_FREE;
          sda_d   = 1'b0;
        end
      end
      ST_SP_FREE: begin
        if (low_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        sda_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sda_q   <= 1'b0;
      bit_q   <= 1'b0;
      done_q  <= 1'b0;
      scl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sda_q   <= sda_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
      scl_q   <= st_scl_pulled(state_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (!busy) cfg_q <= cfg_live;
  end

  assign scl_pd = scl_q;
  assign sda_pd = sda_q;
  assign done   = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!scl_q && !sda_q));

  // R6
  high_sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT_HIGH && $past(state_q) == ST_BIT_HIGH) |-> $stable(sda_q));

  // R6
  stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_wait |=> (ph_cnt == '0));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_tm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             tx_bit,
  input  logic             scl_in,
  output logic             scl_pd,
  output logic             sda_pd,
  output logic             done
);

  timing_t          cfg_live, cfg_eff;
  logic             tick, pre_clear, ph_clr, low_run;
  logic [CNT_W-1:0] ph_cnt, low_cnt;
  logic             unused_rsv;

  assign cfg_live   = unpack_timing(cfg_word);
  assign unused_rsv = ^cfg_word[PRE_LSB-1:SETUP_LSB+DEL_W];

  i2c_tm_prescaler #(.PW(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pre_clear),
    .presc (cfg_eff.presc),
    .tick  (tick)
  );

  i2c_tm_counters #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ph_clr  (ph_clr),
    .low_run (low_run),
    .ph_cnt  (ph_cnt),
    .low_cnt (low_cnt)
  );

  i2c_tm_seq #(.CW(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .tx_bit    (tx_bit),
    .scl_in    (scl_in),
    .cfg_live  (cfg_live),
    .tick      (tick),
    .ph_cnt    (ph_cnt),
    .low_cnt   (low_cnt),
    .cfg_eff   (cfg_eff),
    .pre_clear (pre_clear),
    .ph_clr    (ph_clr),
    .low_run   (low_run),
    .scl_pd    (scl_pd),
    .sda_pd    (sda_pd),
    .done      (done)
  );

endmodule

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd3;
  logic        tx_bit = 1'b0;
  logic        scl_in;
  logic        scl_pd, sda_pd, done;

  int checks = 0;
  int errors = 0;
  int stretch_left = 0;

  int ev_scl[4], ev_sda[4], n_scl, n_sda, t_done, done_cnt;
  int T, H, SU, LO, HI, L;
  logic s0;

  always #10 clk = ~clk;

  assign scl_in = !scl_pd && (stretch_left == 0);

  i2c_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .tx_bit(tx_bit), .scl_in(scl_in),
    .scl_pd(scl_pd), .sda_pd(sda_pd), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int p, input int lo, input int hi, input int hd,
                         input int su, input logic [3:0] rsv);
    cfg_word = {p[3:0], rsv, su[3:0], hd[3:0], hi[7:0], lo[7:0]};
    T = p + 1; H = hd; SU = su; LO = lo; HI = hi;
    L = ((hd + su + 1) > (lo + 1)) ? (hd + su + 1) : (lo + 1);
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic b, input int limit,
                         input int poke_at, input logic [31:0] swap_cfg);
    logic ps, pd;
    logic [31:0] keep;
    keep = cfg_word;
    for (int i = 0; i < 4; i++) begin ev_scl[i] = -1; ev_sda[i] = -1; end
    n_scl = 0; n_sda = 0; t_done = -1; done_cnt = 0;
    ps = scl_pd; pd = sda_pd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; tx_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
    for (int c = 0; c < limit; c++) begin
      if (c > 0) @(negedge clk);
      cmd_valid = 1'b0;
      if (scl_pd != ps) begin if (n_scl < 4) ev_scl[n_scl] = c; n_scl++; ps = scl_pd; end
      if (sda_pd != pd) begin if (n_sda < 4) ev_sda[n_sda] = c; n_sda++; pd = sda_pd; end
      if (done) begin if (t_done < 0) t_done = c; done_cnt++; end
      if (!scl_pd && stretch_left > 0) stretch_left--;
      if (c == poke_at) begin
        cfg_word = swap_cfg; cmd_valid = 1'b1; cmd_op = 2'd2;
      end
      if (t_done >= 0 && c >= t_done + 1) break;
    end
    cmd_valid = 1'b0;
    cfg_word = keep;
  endtask

  task automatic do_start();
    run_cmd(2'd0, 1'b0, 3000, -1, '0);
    check("R3 sda edges", n_sda, 1);
    check("R3 sda pull time", ev_sda[0], 0);
    check("R3 scl pull time", ev_scl[0], (HI + 1) * T);
    check("R9 start done time", t_done, (HI + 1) * T);
    check("R9 start done width", done_cnt, 1);
    s0 = 1'b1;
  endtask

  task automatic do_bit(input logic b, input int stretch, input int poke_at,
                        input logic [31:0] swap_cfg);
    int extra;
    logic nv;
    extra = (stretch > 0) ? stretch - 1 : 0;
    stretch_left = stretch;
    nv = !b;
    run_cmd(2'd1, b, 3000, poke_at, swap_cfg);
    check("R1/R4 sda edge count", n_sda, (nv != s0) ? 1 : 0);
    if (nv != s0) check("R2/R4 sda hold time", ev_sda[0], H * T);
    check("R5 scl edge count", n_scl, 2);
    check("R5 scl release time", ev_scl[0], L * T);
    check("R6 scl pull time", ev_scl[1], (L + HI + 1) * T + extra);
    check("R9 bit done time", t_done, (L + HI + 1) * T + extra);
    check("R9 bit done width", done_cnt, 1);
    check("R4 final sda", int'(sda_pd), int'(nv));
    s0 = nv;
    stretch_left = 0;
  endtask

  task automatic do_rs();
    int k;
    run_cmd(2'd0, 1'b0, 3000, -1, '0);
    k = 0;
    check("R7 sda edge count", n_sda, s0 ? 2 : 1);
    if (s0) begin check("R7 sda release time", ev_sda[0], H * T); k = 1; end
    check("R7 sda pull time", ev_sda[k], (L + LO + 1) * T);
    check("R7 scl release time", ev_scl[0], L * T);
    check("R7 scl pull time", ev_scl[1], (L + LO + 1 + HI + 1) * T);
    check("R9 rs done time", t_done, (L + LO + 1 + HI + 1) * T);
    s0 = 1'b1;
  endtask

  task automatic do_stop();
    int k;
    run_cmd(2'd2, 1'b0, 3000, -1, '0);
    k = 0;
    check("R8 sda edge count", n_sda, s0 ? 1 : 2);
    if (!s0) begin check("R8 sda pull time", ev_sda[0], H * T); k = 1; end
    check("R8 sda release time", ev_sda[k], (L + HI + 1) * T);
    check("R8 scl edge count", n_scl, 1);
    check("R8 scl release time", ev_scl[0], L * T);
    check("R8 bus free done time", t_done, (L + HI + 1 + LO + 1) * T);
    check("R9 stop done width", done_cnt, 1);
    s0 = 1'b0;
  endtask

  task automatic expect_ignored(input logic [1:0] op, input string tag);
    logic ps, pd;
    ps = scl_pd; pd = sda_pd;
    run_cmd(op, 1'b0, 40, -1, '0);
    check(tag, n_scl + n_sda, 0);
    check(tag, t_done, -1);
    check(tag, int'(scl_pd), int'(ps));
    check(tag, int'(sda_pd), int'(pd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset scl", int'(scl_pd), 0);
    check("R11 reset sda", int'(sda_pd), 0);
    check("R11 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    n = 0;
    for (int pi = 0; pi < 3; pi++)
      for (int li = 0; li < 2; li++)
        for (int hi = 0; hi < 2; hi++)
          for (int di = 0; di < 3; di++)
            for (int si = 0; si < 3; si++) begin
              set_cfg((pi == 2) ? 3 : pi, 2 + 3 * li, 1 + 2 * hi,
                      (di == 2) ? 3 : di, (si == 2) ? 6 : 2 * si,
                      n[0] ? 4'hA : 4'h5);
              n++;
              do_start();
              do_bit(1'b0, 0, -1, '0);
              do_bit(1'b1, 0, -1, '0);
              do_bit(1'b1, 0, -1, '0);
              do_rs();
              do_bit(1'b0, 0, -1, '0);
              do_stop();
            end

    set_cfg(1, 3, 2, 2, 1, 4'hF);
    // R11 BIT and STOP on a free bus
    expect_ignored(2'd1, "R11 bit in idle");
    expect_ignored(2'd2, "R11 stop in idle");
    do_start();
    // R12 no-op code
    expect_ignored(2'd3, "R12 noop in held");
    // R6 stretch by a slave
    do_bit(1'b0, 8, -1, '0);
    // R10 and R11: timing-word change and stray STOP while busy
    do_bit(1'b1, 0, 3, 32'h3F0F_0707);
    do_bit(1'b0, 0, -1, '0);
    do_stop();
    // R11 idle after stop
    check("R11 idle scl", int'(scl_pd), 0);
    check("R11 idle sda", int'(sda_pd), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule